// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between the bus-facing byte-load logic of a parallel EEPROM and its page sequencer. Every write attempt (address and data) passes through it. In the same cycle it decides whether that byte may be loaded toward the array. It keeps one protect flag, which stands for a nonvolatile bit. It also tracks short command keys that are written as ordinary bytes. One key switches protection on and opens a single page operation for data. A longer key switches protection off after a fixed programming delay.

Key steps have to arrive back to back under page-load timing. Each one must come within `LOAD_WINDOW` clock cycles of the one before it. A longer gap ends the page operation. Any byte that advances a key is consumed and never reaches the array. The flag starts cleared when the device powers up and is left untouched by the functional reset.

Top module: `wprot_seq`

## Requirements
- R1: At power-up `prot_on` is 0 (unprotected). While it is 0, a write that is not a key step gets `wr_allow`=1 in the same cycle. With `wr_valid`=0, `wr_allow` is 0.
- R2: Any write that matches the next expected key step gets `wr_allow`=0.
- R3: The on-key is 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. After it, if no write arrives for `LOAD_WINDOW` cycles, `prot_on` becomes 1 in the cycle after the last cycle of that gap.
- R4: After the on-key, data writes get `wr_allow`=1 even when protected. The first of them fixes the page, which is address bits [14:6]. A later write to a different page gets 0. When the operation ends, protection is left set.
- R5: While `prot_on`=1 and no key is in progress, a write gets `wr_allow`=0 and does not change `prot_on`.
- R6: The off-key is 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, and 0x20 to 0x5555. If its last write is in cycle t, `prot_on` is still 1 in cycle t+`WC_CYCLES` and is 0 from cycle t+`WC_CYCLES`+1. Writes during that wait get `wr_allow`=0.
- R7: A write that breaks a key sends the detector back to idle and is judged as a fresh write. If it is 0xAA to 0x5555, it starts a new key (allow 0). Otherwise its allow is the inverse of `prot_on`.
- R8: A key step that arrives `LOAD_WINDOW` cycles after the previous write still counts. One cycle later the detector is idle again.
- R9: Key addresses are compared over the full 15-bit width. For example, 0xAA to 0x1555 is an ordinary write.
- R10: A functional reset (`rst_n`=0) clears the key detector and leaves `prot_on` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low; does not touch the protect flag |
| wr_valid | input | 1 | A byte write attempt is present this cycle |
| wr_addr | input | AW (15) | Byte address of the attempt |
| wr_data | input | DW (8) | Data byte of the attempt |
| wr_allow | output | 1 | Same-cycle qualifier: this byte may go to the page sequencer |
| prot_on | output | 1 | Current protection state |

## Verification
The bench probes the timing boundaries. It checks the last cycle in which a key step still counts, and the exact cycle in which protection sets after the on-key gap and clears after the programming delay. A counter off by one would let a late key complete or drop the flag one cycle early or late. It also checks that a broken key hands its breaking byte back to normal judgement, or restarts the key on 0xAA to 0x5555. A design that always went idle would either swallow that byte or lose the restart. Other cases are an aliased key address, a write to a second page inside the opened operation, and a reset in the middle of a key. Each exposes a design that decodes partial addresses, lets a second page through, or clears the flag on a functional reset.

// File: rtl/wprot_seq.sv
module wprot_seq #(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int PAGE_LSB    = 6,
  parameter int LOAD_WINDOW = 8,
  parameter int WC_CYCLES   = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_allow,
  output logic          prot_on
);
  localparam int GW = $clog2(LOAD_WINDOW + 1);
  localparam int CW = $clog2(WC_CYCLES + 1);
  localparam int PW = AW - PAGE_LSB;
  localparam logic [AW-1:0] ADR_HI = AW'('h5555);
  localparam logic [AW-1:0] ADR_LO = AW'('h2AAA);
  localparam logic [DW-1:0] D_AA = DW'('hAA);
  localparam logic [DW-1:0] D_55 = DW'('h55);
  localparam logic [DW-1:0] D_A0 = DW'('hA0);
  localparam logic [DW-1:0] D_80 = DW'('h80);
  localparam logic [DW-1:0] D_20 = DW'('h20);

  typedef enum logic [2:0] {
    S_IDLE, S_K1, S_K2, S_OFF1, S_OFF2, S_OFF3, S_ONKEY, S_WAIT
  } st_t;

  st_t           st_q, st_d;
  logic [GW-1:0] gap_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] page_q;
  logic          page_set_q;
  logic          prot_q = 1'b0;

  logic hit_aa, hit_55, hit_a0, hit_80, hit_20;
  logic step, in_key, timeout, wait_done, page_ok;
  logic set_prot, clr_prot;
  logic st_idle, st_onkey, st_wait;

  assign hit_aa = (wr_addr == ADR_HI) && (wr_data == D_AA);
  assign hit_55 = (wr_addr == ADR_LO) && (wr_data == D_55);
  assign hit_a0 = (wr_addr == ADR_HI) && (wr_data == D_A0);
  assign hit_80 = (wr_addr == ADR_HI) && (wr_data == D_80);
  assign hit_20 = (wr_addr == ADR_HI) && (wr_data == D_20);

  assign in_key    = st_q inside {S_K1, S_K2, S_OFF1, S_OFF2, S_OFF3, S_ONKEY};
  assign timeout   = in_key && !wr_valid && (gap_q == GW'(LOAD_WINDOW - 1));
  assign wait_done = (st_q == S_WAIT) && (cnt_q == CW'(WC_CYCLES - 1));
  assign page_ok   = !page_set_q || (wr_addr[AW-1:PAGE_LSB] == page_q);
  assign set_prot  = rst_n && timeout && (st_q == S_ONKEY);
  assign clr_prot  = rst_n && wait_done;

  always_comb begin
    case (st_q)
      S_IDLE:  step = hit_aa;
      S_K1:    step = hit_55;
      S_K2:    step = hit_a0 | hit_80;
      S_OFF1:  step = hit_aa;
      S_OFF2:  step = hit_55;
      S_OFF3:  step = hit_20;
      default: step = 1'b0;
    endcase
  end

  always_comb begin
    wr_allow = 1'b0;
    if (wr_valid) begin
      case (st_q)
        S_WAIT:  wr_allow = 1'b0;
        S_ONKEY: wr_allow = page_ok;
        default: wr_allow = !step && !hit_aa && !prot_q;
      endcase
    end
  end

  always_comb begin
    st_d = st_q;
    if (st_q == S_WAIT) begin
      if (wait_done) st_d = S_IDLE;
    end else if (timeout) begin
      st_d = S_IDLE;
    end else if (wr_valid && st_q != S_ONKEY) begin
      if (step) begin
        case (st_q)
          S_IDLE:  st_d = S_K1;
          S_K1:    st_d = S_K2;
          S_K2:    st_d = hit_a0 ? S_ONKEY : S_OFF1;
          S_OFF1:  st_d = S_OFF2;
          S_OFF2:  st_d = S_OFF3;
          S_OFF3:  st_d = S_WAIT;
          default: st_d = S_IDLE;
        endcase
      end else begin
        st_d = hit_aa ? S_K1 : S_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      gap_q      <= '0;
      cnt_q      <= '0;
      page_q     <= '0;
      page_set_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (wr_valid) gap_q <= '0;
      else if (gap_q != GW'(LOAD_WINDOW - 1)) gap_q <= gap_q + 1'b1;
      if (st_q != S_WAIT) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
      if (st_q != S_ONKEY) begin
        page_set_q <= 1'b0;
      end else if (wr_valid && !page_set_q) begin
        page_set_q <= 1'b1;
        page_q     <= wr_addr[AW-1:PAGE_LSB];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (set_prot) prot_q <= 1'b1;
    else if (clr_prot) prot_q <= 1'b0;
  end

  assign prot_on  = prot_q;
  assign st_idle  = (st_q == S_IDLE);
  assign st_onkey = (st_q == S_ONKEY);
  assign st_wait  = (st_q == S_WAIT);
endmodule

// File: rtl/wprot_seq_chk.sv
module wprot_seq_chk #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          wr_allow,
  input logic          prot_on,
  input logic          st_idle,
  input logic          st_onkey,
  input logic          st_wait
);
  logic start_key;
  assign start_key = (wr_addr == AW'('h5555)) && (wr_data == DW'('hAA));

  assert_allow_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> !wr_allow);

  assert_key_start_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && wr_valid && start_key |-> !wr_allow);

  assert_set_after_onkey_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $past(st_onkey));

  assert_locked_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prot_on && st_idle && wr_valid && !start_key |-> !wr_allow);

  assert_clear_after_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(st_wait));

  assert_wait_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_wait |-> !wr_allow);
endmodule

bind wprot_seq wprot_seq_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk, .rst_n, .wr_valid, .wr_addr, .wr_data, .wr_allow, .prot_on,
  .st_idle, .st_onkey, .st_wait
);

// File: tb/test_wprot_seq.sv
module test_wprot_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_allow, prot_on;

  int checks = 0;
  int errors = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  wprot_seq i_wprot_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_allow(wr_allow), .prot_on(prot_on)
  );

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit exp, input string tag);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b0;
    end
  endtask

  task automatic check_prot(input bit exp, input string tag);
    checks++;
    if (prot_on !== exp) begin
      errors++;
      $display("FAIL %s prot_on actual=%0b expected=%0b", tag, prot_on, exp);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (wr_valid) begin
      bit exp;
      string tag;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty wr_allow actual=%0b expected=none", wr_allow);
      end else begin
        exp = exp_q.pop_front();
        tag = tag_q.pop_front();
        if (wr_allow !== exp) begin
          errors++;
          $display("FAIL %s wr_allow actual=%0b expected=%0b addr=%h data=%h",
                   tag, wr_allow, exp, wr_addr, wr_data);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check_prot(1'b0, "R1 power-up");
    wr(15'h0123, 8'h5A, 1'b1, "R1 plain write");
    // R9 aliased key address is plain data
    wr(15'h1555, 8'hAA, 1'b1, "R9 alias");
    wr(15'h2AAA, 8'h55, 1'b1, "R9 no key in progress");
    // R8 late step
    wr(15'h5555, 8'hAA, 1'b0, "R2 key start");
    idle(8);
    wr(15'h2AAA, 8'h55, 1'b1, "R8 late step is plain");
    // R8 on-time step
    wr(15'h5555, 8'hAA, 1'b0, "R2 key start");
    idle(7);
    wr(15'h2AAA, 8'h55, 1'b0, "R8 step at window edge");
    wr(15'h0010, 8'h10, 1'b1, "R7 break judged fresh");
    // R7 break, restart, then on-key
    wr(15'h5555, 8'hAA, 1'b0, "R2 key start");
    wr(15'h2AAA, 8'h56, 1'b1, "R7 bad data fresh");
    wr(15'h5555, 8'hAA, 1'b0, "R2 key start");
    wr(15'h5555, 8'hAA, 1'b0, "R7 restart on AA");
    wr(15'h2AAA, 8'h55, 1'b0, "R2 step two");
    wr(15'h5555, 8'hA0, 1'b0, "R2 step three");
    wr(15'h0040, 8'h11, 1'b1, "R4 first data");
    wr(15'h0041, 8'h22, 1'b1, "R4 same page");
    wr(15'h0080, 8'h33, 1'b0, "R4 other page");
    idle(8);
    check_prot(1'b0, "R3 before gap end");
    idle(1);
    check_prot(1'b1, "R3 set after gap");
    // R5 protected
    wr(15'h0100, 8'h44, 1'b0, "R5 locked write");
    wr(15'h2AAA, 8'h55, 1'b0, "R5 locked write");
    wr(15'h5555, 8'hAA, 1'b0, "R2 key start locked");
    wr(15'h0001, 8'h01, 1'b0, "R7 break while locked");
    idle(1);
    check_prot(1'b1, "R5 flag kept");
    // R4 unlock-once while protected
    wr(15'h5555, 8'hAA, 1'b0, "R2 key");
    wr(15'h2AAA, 8'h55, 1'b0, "R2 key");
    wr(15'h5555, 8'hA0, 1'b0, "R2 key");
    wr(15'h0200, 8'h77, 1'b1, "R4 data while protected");
    idle(9);
    check_prot(1'b1, "R4 kept set");
    // R10 reset mid-key
    wr(15'h5555, 8'hAA, 1'b0, "R2 key");
    wr(15'h2AAA, 8'h55, 1'b0, "R2 key");
    idle(1);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    check_prot(1'b1, "R10 flag survives reset");
    wr(15'h5555, 8'hA0, 1'b0, "R10 detector cleared");
    wr(15'h0300, 8'h99, 1'b0, "R10 still protected");
    // R6 off-key
    wr(15'h5555, 8'hAA, 1'b0, "R6 key");
    wr(15'h2AAA, 8'h55, 1'b0, "R6 key");
    wr(15'h5555, 8'h80, 1'b0, "R6 key");
    wr(15'h5555, 8'hAA, 1'b0, "R6 key");
    wr(15'h2AAA, 8'h55, 1'b0, "R6 key");
    wr(15'h5555, 8'h20, 1'b0, "R6 key last");
    wr(15'h0005, 8'h05, 1'b0, "R6 write during wait");
    idle(19);
    check_prot(1'b1, "R6 still set at t+WC");
    idle(1);
    check_prot(1'b0, "R6 clear at t+WC+1");
    wr(15'h0006, 8'h66, 1'b1, "R1 unprotected again");
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule